// File: doc/BRIEF.md
# Variable-Length Frame CRC Appender

This block formats one frame per slot for a bit-serial transmit chain. Information bits enter on a valid/ready stream. The block computes a frame-quality CRC over them and emits a fixed 288-bit slot in this order: the information bits, the CRC field, then zeros. The zeros cover the all-zero tail where the channel uses one, and the padding. The number of information bits and the CRC length (0, 6, 8, 10 or 12 bits) come from a lookup on channel type, rate set and a 2-bit rate code. The tail, when present, is 8 zero bits.

Channel type and rate set are static configuration inputs. The rate code is sampled together with the start-of-frame strobe. A combination the lookup does not support raises an error flag. Such a slot consumes no input and is sent as 288 zeros. Each slot ends with a done pulse, and a new start is taken only once the block is idle again.

Top module: `frame_crc_appender`

## Requirements
- R1: With channel code 3 (traffic) and rate set 0, rate codes 0/1/2/3 give 172/80/40/16 information bits with 12/8/0/0 CRC bits, followed by zeros up to 288.
- R2: With channel code 3 and rate set 1, rate codes 0/1/2/3 give 268/126/56/22 information bits with 12/10/8/6 CRC bits, followed by zeros up to 288.
- R3: Channel code 0 (sync) with rate 3 gives 32 bits. Channel code 1 (paging) with rate 0 or 1 gives 192 or 96 bits. Channel code 2 (access) with rate 1 gives 88 bits. None of these carries a CRC, and the rate set has no effect on them.
- R4: The CRC register is preset to all ones at frame start and takes information bits first-in-first. It uses x^12+x^11+x^10+x^9+x^8+x^4+x+1, x^10+x^9+x^8+x^7+x^6+x^4+x^3+1, x^8+x^7+x^4+x^3+x+1 or x^6+x^2+x+1, and is emitted highest-order bit first.
- R5: The CRC field directly follows the last information bit. Every later slot position, tail and padding alike, is 0.
- R6: Every slot has exactly 288 output-valid cycles, and frame_done_o is high together with the 288th.
- R7: An unsupported channel/rate combination sets cfg_err_o until the next accepted start. That slot accepts no input bits and outputs 288 zeros.
- R8: sof_i is accepted only while idle and samples rate_i there. A start during a slot, or input bits offered while idle, have no effect.
- R9: bit_ready_o is high only while information bits are still owed. Each accepted bit appears on out_bit_o with out_valid_o one clock later, and stalls on bit_valid_i are honored.
- R10: After reset, out_valid_o, frame_done_o, bit_ready_o and cfg_err_o are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rate_set_i | input | 1 | Rate set select, 0 or 1 (static) |
| chan_i | input | 2 | Channel: 0 sync, 1 paging, 2 access, 3 traffic (static) |
| sof_i | input | 1 | Start-of-frame strobe |
| rate_i | input | 2 | Rate code 0 full, 1 half, 2 quarter, 3 eighth; sampled with sof_i |
| bit_valid_i | input | 1 | Information bit valid |
| bit_i | input | 1 | Information bit |
| bit_ready_o | output | 1 | Block takes an information bit this cycle |
| out_valid_o | output | 1 | Output bit valid |
| out_bit_o | output | 1 | Output bit |
| frame_done_o | output | 1 | High with the last bit of the slot |
| cfg_err_o | output | 1 | Current configuration unsupported |

## Verification
The start strobe is taken at one rising edge, and the slot's first output can appear at the edge after that. Every information bit accepted at an edge is on out_bit_o from that same edge. CRC, tail and padding bits then follow one per cycle, and frame_done_o rises with the 288th valid bit. cfg_err_o is valid from the edge that accepted the start. The bench drives and samples on the falling edge. It predicts acceptance from bit_ready_o at that moment and expects the echoed bit at the very next falling-edge sample. It records the whole slot before comparing the information, CRC and zero zones against its own lookup and CRC model.

// File: rtl/fca_pkg.sv
`timescale 1ns/1ps
package fca_pkg;
  localparam int unsigned LEN_W  = 9;
  localparam int unsigned CLEN_W = 4;

  typedef enum logic [1:0] {
    CH_SYNC    = 2'd0,
    CH_PAGING  = 2'd1,
    CH_ACCESS  = 2'd2,
    CH_TRAFFIC = 2'd3
  } chan_e;

  typedef enum logic [1:0] {
    RT_FULL    = 2'd0,
    RT_HALF    = 2'd1,
    RT_QUARTER = 2'd2,
    RT_EIGHTH  = 2'd3
  } rate_e;

  typedef struct packed {
    logic              ok;
    logic [LEN_W-1:0]  info_len;
    logic [CLEN_W-1:0] crc_len;
  } fmt_t;

  function automatic fmt_t mk_fmt(input logic [LEN_W-1:0] info, input logic [CLEN_W-1:0] crc);
    fmt_t f;
    f.ok       = 1'b1;
    f.info_len = info;
    f.crc_len  = crc;
    return f;
  endfunction
endpackage

// File: rtl/fca_fmt_decode.sv
`timescale 1ns/1ps
module fca_fmt_decode
  import fca_pkg::*;
(
  input  chan_e chan_i,
  input  logic  rate_set_i,
  input  rate_e rate_i,
  output fmt_t  fmt_o
);
  always_comb begin
    fmt_o = '0;
    case (chan_i)
      CH_SYNC:   if (rate_i == RT_EIGHTH) fmt_o = mk_fmt(9'd32, 4'd0);
      CH_PAGING: begin
        if (rate_i == RT_FULL)      fmt_o = mk_fmt(9'd192, 4'd0);
        else if (rate_i == RT_HALF) fmt_o = mk_fmt(9'd96, 4'd0);
      end
      CH_ACCESS: if (rate_i == RT_HALF) fmt_o = mk_fmt(9'd88, 4'd0);
      CH_TRAFFIC: begin
        if (!rate_set_i) begin
          case (rate_i)
            RT_FULL:    fmt_o = mk_fmt(9'd172, 4'd12);
            RT_HALF:    fmt_o = mk_fmt(9'd80, 4'd8);
            RT_QUARTER: fmt_o = mk_fmt(9'd40, 4'd0);
            default:    fmt_o = mk_fmt(9'd16, 4'd0);
          endcase
        end else begin
          case (rate_i)
            RT_FULL:    fmt_o = mk_fmt(9'd268, 4'd12);
            RT_HALF:    fmt_o = mk_fmt(9'd126, 4'd10);
            RT_QUARTER: fmt_o = mk_fmt(9'd56, 4'd8);
            default:    fmt_o = mk_fmt(9'd22, 4'd6);
          endcase
        end
      end
      default: fmt_o = '0;
    endcase
  end
endmodule

// File: rtl/fca_crc_engine.sv
`timescale 1ns/1ps
module fca_crc_engine #(
  parameter int unsigned CRC_W = 12,
  parameter int unsigned LEN_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             init_i,
  input  logic [LEN_W-1:0] len_i,
  input  logic             shift_in_i,
  input  logic             din_i,
  input  logic             shift_out_i,
  output logic             msb_o
);
  localparam logic [CRC_W-1:0] ONES = '1;

  logic [CRC_W-1:0] crc_q, poly, mask;
  logic             top, fb;

  // Feedback taps below the leading term, one mask per supported length
  always_comb begin
    case (len_i)
      LEN_W'(12): poly = CRC_W'(12'hF13);
      LEN_W'(10): poly = CRC_W'(12'h3D9);
      LEN_W'(8):  poly = CRC_W'(12'h09B);
      LEN_W'(6):  poly = CRC_W'(12'h007);
      default:    poly = '0;
    endcase
  end

  always_comb begin
    mask = '0;
    top  = 1'b0;
    for (int k = 0; k < int'(CRC_W); k++) begin
      mask[k] = (k < int'(len_i));
      if (k + 1 == int'(len_i)) top = crc_q[k];
    end
  end

  assign fb    = din_i ^ top;
  assign msb_o = top;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          crc_q <= ONES;
    else if (init_i)      crc_q <= ONES;
    else if (shift_in_i)  crc_q <= ((crc_q << 1) ^ (fb ? poly : '0)) & mask;
    else if (shift_out_i) crc_q <= (crc_q << 1) & mask;
  end
endmodule

// File: rtl/fca_slot_seq.sv
`timescale 1ns/1ps
module fca_slot_seq #(
  parameter int unsigned SLOT_LEN = 288,
  parameter int unsigned LEN_W    = 9,
  parameter int unsigned CLEN_W   = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sof_i,
  input  logic              fmt_ok_i,
  input  logic [LEN_W-1:0]  info_len_i,
  input  logic [CLEN_W-1:0] crc_len_i,
  input  logic              bit_valid_i,
  output logic              accept_o,
  output logic              in_info_o,
  output logic              in_crc_o,
  output logic              step_o,
  output logic              last_o
);
  localparam int unsigned POS_W = $clog2(SLOT_LEN);
  localparam int unsigned CMP_W = (POS_W > LEN_W ? POS_W : LEN_W) + 1;

  logic             busy_q;
  logic [POS_W-1:0] pos_q;
  logic [CMP_W-1:0] pos_w, info_w, crc_end;

  assign pos_w   = CMP_W'(pos_q);
  assign info_w  = CMP_W'(info_len_i);
  assign crc_end = info_w + CMP_W'(crc_len_i);

  assign accept_o  = sof_i & ~busy_q;
  assign in_info_o = busy_q & fmt_ok_i & (pos_w < info_w);
  assign in_crc_o  = busy_q & fmt_ok_i & ~in_info_o & (pos_w < crc_end);
  // Information phase waits on the stream; every other phase advances each cycle
  assign step_o    = busy_q & (~in_info_o | bit_valid_i);
  assign last_o    = step_o & (pos_q == POS_W'(SLOT_LEN - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      pos_q  <= '0;
    end else if (accept_o) begin
      busy_q <= 1'b1;
      pos_q  <= '0;
    end else if (last_o) begin
      busy_q <= 1'b0;
      pos_q  <= '0;
    end else if (step_o) begin
      pos_q  <= pos_q + POS_W'(1);
    end
  end
endmodule

// File: rtl/frame_crc_appender.sv
`timescale 1ns/1ps
module frame_crc_appender
  import fca_pkg::*;
#(
  parameter int unsigned SLOT_LEN = 288,
  parameter int unsigned CRC_W    = 12
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       rate_set_i,
  input  logic [1:0] chan_i,
  input  logic       sof_i,
  input  logic [1:0] rate_i,
  input  logic       bit_valid_i,
  input  logic       bit_i,
  output logic       bit_ready_o,
  output logic       out_valid_o,
  output logic       out_bit_o,
  output logic       frame_done_o,
  output logic       cfg_err_o
);
  chan_e chan_q;
  rate_e rate_q;
  logic  rs_q, seen_q;
  fmt_t  fmt;
  logic  accept, in_info, in_crc, step, last, crc_msb;
  logic  ov_q, ob_q, done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      chan_q <= CH_SYNC;
      rate_q <= RT_FULL;
      rs_q   <= 1'b0;
      seen_q <= 1'b0;
    end else if (accept) begin
      chan_q <= chan_e'(chan_i);
      rate_q <= rate_e'(rate_i);
      rs_q   <= rate_set_i;
      seen_q <= 1'b1;
    end
  end

  fca_fmt_decode u_dec (
    .chan_i     (chan_q),
    .rate_set_i (rs_q),
    .rate_i     (rate_q),
    .fmt_o      (fmt)
  );

  fca_slot_seq #(
    .SLOT_LEN (SLOT_LEN),
    .LEN_W    (LEN_W),
    .CLEN_W   (CLEN_W)
  ) u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .sof_i       (sof_i),
    .fmt_ok_i    (fmt.ok),
    .info_len_i  (fmt.info_len),
    .crc_len_i   (fmt.crc_len),
    .bit_valid_i (bit_valid_i),
    .accept_o    (accept),
    .in_info_o   (in_info),
    .in_crc_o    (in_crc),
    .step_o      (step),
    .last_o      (last)
  );

  fca_crc_engine #(
    .CRC_W (CRC_W),
    .LEN_W (CLEN_W)
  ) u_crc (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .init_i      (accept),
    .len_i       (fmt.crc_len),
    .shift_in_i  (in_info & bit_valid_i),
    .din_i       (bit_i),
    .shift_out_i (in_crc),
    .msb_o       (crc_msb)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ov_q   <= 1'b0;
      ob_q   <= 1'b0;
      done_q <= 1'b0;
    end else begin
      ov_q   <= step;
      ob_q   <= in_info ? bit_i : (in_crc & crc_msb);
      done_q <= last;
    end
  end

  assign bit_ready_o  = in_info;
  assign out_valid_o  = ov_q;
  assign out_bit_o    = ob_q;
  assign frame_done_o = done_q;
  assign cfg_err_o    = seen_q & ~fmt.ok;
endmodule

// File: rtl/fca_checker.sv
`timescale 1ns/1ps
module fca_checker #(
  parameter int unsigned SLOT_LEN = 288
) (
  input logic clk_i,
  input logic rst_ni,
  input logic bit_valid_i,
  input logic bit_i,
  input logic bit_ready_o,
  input logic out_valid_o,
  input logic out_bit_o,
  input logic frame_done_o,
  input logic cfg_err_o
);
  localparam int unsigned CNT_W = $clog2(SLOT_LEN + 1);
  logic [CNT_W-1:0] vcnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           vcnt_q <= '0;
    else if (frame_done_o) vcnt_q <= '0;
    else if (out_valid_o)  vcnt_q <= vcnt_q + CNT_W'(1);
  end

  AST_ECHO_NEXT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bit_valid_i && bit_ready_o) |=> (out_valid_o && out_bit_o == $past(bit_i))); // R9
  AST_DONE_WITH_BIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_done_o |-> out_valid_o); // R6
  AST_SLOT_COUNT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_done_o |-> (vcnt_q == CNT_W'(SLOT_LEN - 1))); // R6
  AST_ERR_ZEROS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_err_o && out_valid_o) |-> !out_bit_o); // R7
  AST_IDLE_AFTER_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_done_o |-> !bit_ready_o); // R8
endmodule

bind frame_crc_appender fca_checker #(.SLOT_LEN(SLOT_LEN)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .bit_valid_i  (bit_valid_i),
  .bit_i        (bit_i),
  .bit_ready_o  (bit_ready_o),
  .out_valid_o  (out_valid_o),
  .out_bit_o    (out_bit_o),
  .frame_done_o (frame_done_o),
  .cfg_err_o    (cfg_err_o)
);

// File: tb/frame_crc_appender_test.sv
`timescale 1ns/1ps
module frame_crc_appender_test;
  localparam int SLOT = 288;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rate_set = 1'b0;
  logic [1:0] chan = 2'd0;
  logic       sof = 1'b0;
  logic [1:0] rate = 2'd0;
  logic       bvalid = 1'b0;
  logic       bdata = 1'b0;
  logic       bready, ovalid, obit, done, cerr;

  frame_crc_appender uut (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .rate_set_i   (rate_set),
    .chan_i       (chan),
    .sof_i        (sof),
    .rate_i       (rate),
    .bit_valid_i  (bvalid),
    .bit_i        (bdata),
    .bit_ready_o  (bready),
    .out_valid_o  (ovalid),
    .out_bit_o    (obit),
    .frame_done_o (done),
    .cfg_err_o    (cerr)
  );

  always #10 clk = ~clk;

  int   total = 0;
  int   bad = 0;
  bit   finished = 0;
  logic info_bits [SLOT];
  logic obuf [SLOT];
  logic [15:0] prng = 16'hACE1;

  typedef struct packed {
    logic [1:0] ch;
    logic       rs;
    logic [1:0] rt;
    logic       gap;
    logic       stray;
  } vec_t;

  // ch: 0 sync, 1 paging, 2 access, 3 traffic
  localparam vec_t VECS [16] = '{
    '{2'd3, 1'b0, 2'd0, 1'b0, 1'b0},
    '{2'd3, 1'b0, 2'd1, 1'b1, 1'b0},
    '{2'd3, 1'b0, 2'd2, 1'b0, 1'b1},
    '{2'd3, 1'b0, 2'd3, 1'b1, 1'b0},
    '{2'd3, 1'b1, 2'd0, 1'b1, 1'b1},
    '{2'd3, 1'b1, 2'd1, 1'b0, 1'b0},
    '{2'd3, 1'b1, 2'd2, 1'b1, 1'b0},
    '{2'd3, 1'b1, 2'd3, 1'b0, 1'b1},
    '{2'd0, 1'b0, 2'd3, 1'b0, 1'b0},
    '{2'd0, 1'b1, 2'd3, 1'b1, 1'b0},
    '{2'd1, 1'b0, 2'd0, 1'b0, 1'b1},
    '{2'd1, 1'b1, 2'd1, 1'b1, 1'b0},
    '{2'd2, 1'b0, 2'd1, 1'b0, 1'b0},
    '{2'd0, 1'b0, 2'd0, 1'b0, 1'b0},
    '{2'd1, 1'b0, 2'd2, 1'b1, 1'b0},
    '{2'd2, 1'b1, 2'd0, 1'b0, 1'b0}
  };

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic void ref_fmt(input int ch, input int rs, input int rt,
                                  output bit ok, output int info, output int crc);
    ok = 1; info = 0; crc = 0;
    if (ch == 0 && rt == 3) info = 32;
    else if (ch == 1 && rt == 0) info = 192;
    else if (ch == 1 && rt == 1) info = 96;
    else if (ch == 2 && rt == 1) info = 88;
    else if (ch == 3 && rs == 0) begin
      case (rt)
        0: begin info = 172; crc = 12; end
        1: begin info = 80;  crc = 8;  end
        2: info = 40;
        default: info = 16;
      endcase
    end else if (ch == 3) begin
      case (rt)
        0: begin info = 268; crc = 12; end
        1: begin info = 126; crc = 10; end
        2: begin info = 56;  crc = 8;  end
        default: begin info = 22; crc = 6; end
      endcase
    end else ok = 0;
  endfunction

  function automatic int ref_poly(input int len);
    case (len)
      12: return 'hF13;
      10: return 'h3D9;
      8:  return 'h09B;
      6:  return 'h007;
      default: return 0;
    endcase
  endfunction

  function automatic int ref_crc(input int n, input int len);
    int r = (1 << len) - 1;
    for (int i = 0; i < n; i++) begin
      int fb = int'(info_bits[i]) ^ ((r >> (len - 1)) & 1);
      r = (r << 1) & ((1 << len) - 1);
      if (fb != 0) r = r ^ ref_poly(len);
    end
    return r;
  endfunction

  task automatic run_frame(input int ch, input int rs, input int rt,
                           input bit gap, input bit stray, input int fill);
    bit   ok;
    int   info, crc, crcv, grpn;
    int   idx = 0, ocnt = 0, done_at = -1, lat_bad = 0;
    int   info_mis = 0, crc_mis = 0, rest_mis = 0;
    bit   acc = 0;
    logic last_bit = 1'b0;
    logic e;
    string grp;
    ref_fmt(ch, rs, rt, ok, info, crc);
    for (int i = 0; i < SLOT; i++) begin
      prng = {prng[14:0], prng[15] ^ prng[13] ^ prng[12] ^ prng[10]};
      info_bits[i] = (fill == 1) ? 1'b0 : (fill == 2) ? 1'b1 : prng[0];
      obuf[i] = 1'bx;
    end
    @(negedge clk);
    chan = 2'(ch); rate_set = rs[0]; rate = 2'(rt); sof = 1'b1;
    @(negedge clk);
    for (int cyc = 0; cyc < 3000; cyc++) begin
      if (acc && !(ovalid === 1'b1 && obit === last_bit)) lat_bad++;
      if (ovalid === 1'b1) begin
        if (ocnt < SLOT) obuf[ocnt] = obit;
        ocnt++;
      end
      if (done === 1'b1) begin
        done_at = ocnt;
        break;
      end
      sof      = stray && cyc == 40;
      rate     = 2'(rt) ^ 2'b01;
      bvalid   = (idx < (ok ? info : 40)) && (!gap || (cyc % 3) != 1);
      bdata    = (idx < SLOT) ? info_bits[idx] : 1'b0;
      acc      = bvalid && (bready === 1'b1);
      last_bit = bdata;
      @(negedge clk);
      if (acc) idx++;
    end
    bvalid = 1'b0;
    sof    = 1'b0;
    crcv   = ref_crc(info, crc);
    for (int p = 0; p < SLOT; p++) begin
      if (!ok) e = 1'b0;
      else if (p < info) e = info_bits[p];
      else if (p < info + crc) e = logic'((crcv >> (crc - 1 - (p - info))) & 1);
      else e = 1'b0;
      if (obuf[p] !== e) begin
        if (ok && p < info) info_mis++;
        else if (ok && p < info + crc) crc_mis++;
        else rest_mis++;
      end
    end
    grpn = (ch == 3) ? (rs == 0 ? 1 : 2) : 3;
    grp  = (grpn == 1) ? "R1" : (grpn == 2) ? "R2" : "R3";
    chk(done_at == SLOT, $sformatf("R6 slot length ch%0d rs%0d rt%0d", ch, rs, rt), done_at, SLOT);
    chk(info_mis == 0, $sformatf("%s info zone ch%0d rs%0d rt%0d", grp, ch, rs, rt), info_mis, 0);
    chk(crc_mis == 0, $sformatf("R4 crc field len%0d ch%0d rs%0d rt%0d", crc, ch, rs, rt), crc_mis, 0);
    chk(rest_mis == 0, ok ? $sformatf("R5 tail/pad zeros ch%0d rt%0d", ch, rt)
                          : $sformatf("R7 zero frame ch%0d rt%0d", ch, rt), rest_mis, 0);
    chk(idx == (ok ? info : 0), ok ? "R9 bits consumed" : "R7 no input taken", idx, ok ? info : 0);
    chk(lat_bad == 0, "R9 one-cycle echo under stalls", lat_bad, 0);
    chk(cerr === !ok, "R7 cfg_err_o level", int'(cerr), int'(!ok));
    if (stray) chk(info_mis + crc_mis + rest_mis == 0, "R8 start during slot ignored",
                   info_mis + crc_mis + rest_mis, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(ovalid === 1'b0 && done === 1'b0 && bready === 1'b0 && cerr === 1'b0,
        "R10 reset outputs", int'({ovalid, done, bready, cerr}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(ovalid === 1'b0 && bready === 1'b0, "R10 idle after release", int'({ovalid, bready}), 0);

    // R8: bits offered with no start are not taken
    bvalid = 1'b1;
    begin
      int seen = 0;
      for (int i = 0; i < 8; i++) begin
        @(negedge clk);
        if (ovalid !== 1'b0 || bready !== 1'b0) seen++;
      end
      chk(seen == 0, "R8 idle ignores input", seen, 0);
    end
    bvalid = 1'b0;

    for (int v = 0; v < 16; v++)
      run_frame(int'(VECS[v].ch), int'(VECS[v].rs), int'(VECS[v].rt),
                VECS[v].gap, VECS[v].stray, 0);

    // Corner patterns for each CRC length: all-zero and all-one payloads
    run_frame(3, 1, 0, 1'b0, 1'b0, 1);
    run_frame(3, 1, 1, 1'b1, 1'b0, 2);
    run_frame(3, 1, 3, 1'b0, 1'b0, 2);
    run_frame(3, 0, 1, 1'b0, 1'b0, 1);
    // Error frame followed directly by a good one: flag must clear
    run_frame(0, 0, 1, 1'b0, 1'b0, 0);
    run_frame(3, 0, 0, 1'b1, 1'b0, 2);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #3000000;
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL R6 watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule